// File: doc/BRIEF.md
# Multiplexed BCD digit scanner

This block presents one latched conversion result on a narrow 4-bit BCD bus. It shows one digit position at a time and drives four active-high digit-select lines. The result consists of three BCD digits (hundreds, tens, units), a half-digit that reads either 0 or 1, a sign, and two range flags. The most significant position does not carry a plain digit. Instead it carries a packed status code that combines the half-digit, the sign and the range flags.

A full scan lasts four slots of 20 clocks each, so the scan repeats every 80 clocks. Each slot begins with a 2-clock blanking gap. During the gap no select is high, but the bus already holds the slot's data, so the data has settled before its select rises. An end-of-conversion pulse captures the result inputs into the frame that is displayed and restarts the scan at the most significant position. Between pulses the scan runs freely on the last captured frame. A display frame therefore never mixes data from two conversions.

Top module: `bcd_scan_mux`

## Requirements
- R1: While reset is asserted, and in the first frame after it, no select is high during gaps. The captured frame is all zero, so the status slot shows 1110 and each digit slot shows 0000.
- R2: A clock edge with `eoc` high restarts the scan. The two clocks after that edge are blanking, and then `dsel[3]` (the status slot) goes high. This holds even when the pulse arrives in the middle of a scan.
- R3: Selects turn on in the order `dsel[3]`, `dsel[2]`, `dsel[1]`, `dsel[0]`, and the sequence then wraps back to `dsel[3]`.
- R4: Each slot lasts 20 clocks. The first 2 clocks have all selects low, and the slot's select is high for the remaining 18 clocks.
- R5: Without a new `eoc`, the 80-clock scan repeats with identical select and bus values.
- R6: At most one select is high in any cycle.
- R7: For the whole slot, including its gap, the bus carries hundreds during the `dsel[2]` slot, tens during the `dsel[1]` slot, and units during the `dsel[0]` slot.
- R8: The status slot carries the following bits:
  - bit 3 is low when the half-digit is 1 and high when it is 0.
  - bit 2 is 1 for a positive result and 0 for a negative result.
  - bit 1 is high unless the value is an in-range 1xxx.
  - bit 0 is 0 when the value is in range.
  - The resulting codes are: +0 = 1110, -0 = 1010, +1 = 0100, -1 = 0000.
- R9: When a range flag is set, bit 0 is 1 and bit 3 gives the range type: 0 means overrange and 1 means underrange. The resulting codes are: +1 over = 0111, -1 over = 0011, +0 under = 1111, -0 under = 1011. If both flags are set, overrange wins.
- R10: Result inputs are sampled only on an `eoc` edge. Changes at any other time do not affect the bus.
- R11: The bus does not change while a select stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eoc | input | 1 | End-of-conversion pulse: captures the result and restarts the scan |
| hund | input | 4 | Hundreds BCD digit of the result |
| tens | input | 4 | Tens BCD digit of the result |
| units | input | 4 | Units BCD digit of the result |
| half_one | input | 1 | Half-digit is 1 |
| negative | input | 1 | Result is negative |
| over_rng | input | 1 | Overrange flag |
| under_rng | input | 1 | Underrange flag |
| bcd | output | 4 | Multiplexed BCD or status code |
| dsel | output | 4 | One-hot digit selects; bit 3 is the status slot |

## Verification
A slot counter that has slipped shows up at the ports within one slot (20 clocks). It appears either as a select that rises or falls on the wrong cycle, or as a gap that is not exactly two clocks long. A wrong slot index appears as an out-of-order select, or as the bus carrying the wrong digit for the select that is high. Frame capture at the wrong time is visible within two clocks of a restart, because the status code or digits then follow the live inputs instead of the frame captured at `eoc`. Every cycle of each 80-clock frame is compared against expected select and bus values.

// File: rtl/bcd_scan_mux.sv
module bcd_scan_mux #(
  parameter int SLOT_CLKS = 20,
  parameter int GAP_CLKS  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       eoc,
  input  logic [3:0] hund,
  input  logic [3:0] tens,
  input  logic [3:0] units,
  input  logic       half_one,
  input  logic       negative,
  input  logic       over_rng,
  input  logic       under_rng,
  output logic [3:0] bcd,
  output logic [3:0] dsel
);
  localparam int CW = $clog2(SLOT_CLKS);

  logic [CW-1:0] cnt;
  logic [1:0]    slot;
  logic [3:0]    f_hund, f_tens, f_units;
  logic          f_half, f_neg, f_over, f_under;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      slot    <= '0;
      f_hund  <= '0;
      f_tens  <= '0;
      f_units <= '0;
      f_half  <= 1'b0;
      f_neg   <= 1'b0;
      f_over  <= 1'b0;
      f_under <= 1'b0;
    end else if (eoc) begin
      cnt     <= '0;
      slot    <= '0;
      f_hund  <= hund;
      f_tens  <= tens;
      f_units <= units;
      f_half  <= half_one;
      f_neg   <= negative;
      f_over  <= over_rng;
      f_under <= under_rng;
    end else if (cnt == CW'(SLOT_CLKS - 1)) begin
      cnt  <= '0;
      slot <= slot + 2'd1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  wire       oor  = f_over | f_under;
  wire       q3   = f_over ? 1'b0 : (f_under ? 1'b1 : ~f_half);
  wire [3:0] stat = {q3, ~f_neg, ~f_half | oor, oor};

  always_comb begin
    case (slot)
      2'd0:    bcd = stat;
      2'd1:    bcd = f_hund;
      2'd2:    bcd = f_tens;
      default: bcd = f_units;
    endcase
  end

  assign dsel = (cnt >= CW'(GAP_CLKS)) ? (4'b1000 >> slot) : 4'b0000;
endmodule

// File: rtl/bcd_scan_mux_chk.sv
module bcd_scan_mux_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       eoc,
  input logic [3:0] bcd,
  input logic [3:0] dsel
);
  logic [3:0] last_sel;
  logic [3:0] next_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_sel <= 4'b0000;
    else if (eoc)     last_sel <= 4'b0000;
    else if (|dsel)   last_sel <= dsel;
  end

  assign next_sel = (last_sel == 4'b0000 || last_sel[0]) ? 4'b1000 : (last_sel >> 1);

  p_sel_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dsel));

  p_restart_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> (dsel == 4'b0000));

  p_sel_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|dsel) |-> (dsel == next_sel));

  p_gap_between_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|$past(dsel)) && (dsel != $past(dsel))) |-> (dsel == 4'b0000));

  p_bus_steady_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((|dsel) && (|$past(dsel))) |-> $stable(bcd));
endmodule

bind bcd_scan_mux bcd_scan_mux_chk u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .eoc  (eoc),
  .bcd  (bcd),
  .dsel (dsel)
);

// File: tb/bcd_scan_mux_test.sv
module bcd_scan_mux_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       eoc = 1'b0;
  logic [3:0] hund = '0, tens = '0, units = '0;
  logic       half_one = 1'b0, negative = 1'b0, over_rng = 1'b0, under_rng = 1'b0;
  logic [3:0] bcd, dsel;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bcd_scan_mux uut (
    .clk(clk), .rst_n(rst_n), .eoc(eoc),
    .hund(hund), .tens(tens), .units(units),
    .half_one(half_one), .negative(negative),
    .over_rng(over_rng), .under_rng(under_rng),
    .bcd(bcd), .dsel(dsel)
  );

  task automatic check4(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_result(input logic [3:0] h, input logic [3:0] t, input logic [3:0] u,
                            input logic hf, input logic ng, input logic ov, input logic un);
    hund = h; tens = t; units = u;
    half_one = hf; negative = ng; over_rng = ov; under_rng = un;
  endtask

  // Pulse eoc for one edge; returns at the negedge that is offset 0 of the new scan.
  task automatic pulse_eoc();
    eoc = 1'b1;
    @(negedge clk);
    eoc = 1'b0;
  endtask

  // Checks 80 cycles from offset 0; returns at offset 0 of the following scan.
  task automatic check_frame(input string tag, input logic [3:0] code,
                             input logic [3:0] h, input logic [3:0] t, input logic [3:0] u);
    for (int i = 0; i < 80; i++) begin
      int s = i / 20;
      int c = i % 20;
      logic [3:0] es = (c < 2) ? 4'b0000 : (4'b1000 >> s);
      logic [3:0] eb = (s == 0) ? code : (s == 1) ? h : (s == 2) ? t : u;
      check4("R2/R3/R4/R5/R6 dsel", dsel, es);
      check4((s == 0) ? tag : "R7/R11 digit", bcd, eb);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check4("R1 reset dsel", dsel, 4'b0000);
    check4("R1 reset bcd", bcd, 4'b1110);
    rst_n = 1'b1;
    check_frame("R1 first frame status", 4'b1110, 4'h0, 4'h0, 4'h0);
  endtask

  task automatic t_code(input string tag, input logic hf, input logic ng,
                        input logic ov, input logic un, input logic [3:0] code);
    set_result(4'h3, 4'h5, 4'h8, hf, ng, ov, un);
    pulse_eoc();
    check_frame(tag, code, 4'h3, 4'h5, 4'h8);
  endtask

  task automatic t_digits_repeat();
    set_result(4'h7, 4'h4, 4'h9, 1'b1, 1'b0, 1'b0, 1'b0);
    pulse_eoc();
    check_frame("R7 status", 4'b0100, 4'h7, 4'h4, 4'h9);
    check_frame("R5 repeat status", 4'b0100, 4'h7, 4'h4, 4'h9);
  endtask

  task automatic t_hold_frame();
    set_result(4'h1, 4'h2, 4'h6, 1'b0, 1'b1, 1'b0, 1'b0);
    pulse_eoc();
    set_result(4'h9, 4'h9, 4'h9, 1'b1, 1'b0, 1'b1, 1'b0);  // R10: must not show
    check_frame("R10 status held", 4'b1010, 4'h1, 4'h2, 4'h6);
  endtask

  task automatic t_mid_restart();
    set_result(4'h2, 4'h0, 4'h5, 1'b0, 1'b0, 1'b0, 1'b0);
    pulse_eoc();
    repeat (45) @(negedge clk);
    set_result(4'h6, 4'h1, 4'h3, 1'b1, 1'b1, 1'b0, 1'b0);
    pulse_eoc();  // R2 restart mid-scan
    check_frame("R2 restart status", 4'b0000, 4'h6, 4'h1, 4'h3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_code("R8 +0",      1'b0, 1'b0, 1'b0, 1'b0, 4'b1110);
    t_code("R8 -0",      1'b0, 1'b1, 1'b0, 1'b0, 4'b1010);
    t_code("R8 +1",      1'b1, 1'b0, 1'b0, 1'b0, 4'b0100);
    t_code("R8 -1",      1'b1, 1'b1, 1'b0, 1'b0, 4'b0000);
    t_code("R9 +1 over", 1'b1, 1'b0, 1'b1, 1'b0, 4'b0111);
    t_code("R9 -1 over", 1'b1, 1'b1, 1'b1, 1'b0, 4'b0011);
    t_code("R9 +0 under",1'b0, 1'b0, 1'b0, 1'b1, 4'b1111);
    t_code("R9 -0 under",1'b0, 1'b1, 1'b0, 1'b1, 4'b1011);
    t_code("R9 both",    1'b1, 1'b0, 1'b1, 1'b1, 4'b0111);
    t_digits_repeat();
    t_hold_frame();
    t_mid_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule